// File: doc/BRIEF.md
# Fixed-Point Vertex Transform Unit

This block carries one homogeneous vertex through the front of a fixed-function geometry pipeline. Software or a preceding stage writes sixteen transform coefficients and the four vertex components over a word-wide load port. It then raises `start`. The unit multiplies the matrix by the vertex as a column vector and divides the resulting x, y and z by the resulting w to reach normalized device coordinates. It then maps x and y into pixel space using the screen width and height present on its inputs.

All arithmetic is signed fixed point with 16 integer bits and 16 fraction bits. A mode input selects, for the multiply-accumulate and viewport steps, whether an out-of-range result clamps to the extreme representable value or wraps. Clamping keeps a vertex that is in view from changing sign and appearing behind the eye. A single state machine runs the sixteen multiply-accumulate steps, then three parallel bit-serial dividers, then a one-cycle viewport stage. It announces the result with a one-cycle `done` pulse.

Top module: `vtx_xform_unit`

## Requirements
- R1: A fixed-point product is the full 64-bit signed product shifted right arithmetically by 16, so discarded bits round toward negative infinity (for example -1 LSB times 0.5 gives -1 LSB).
- R2: The transformed component i equals the sum over j of M[i][j]·v[j], accumulated in j order 0 to 3. The matrix post-multiplies the column vector.
- R3: `done` rises exactly 67 clock cycles after the rising edge that accepts `start`, and `busy` is high from the cycle after acceptance until `done` rises. The 67 cycles are 16 multiply-accumulate cycles, 48 divider cycles and 3 control cycles.
- R4: `ndc_z`, and the x and y values fed to the viewport, equal the transformed component divided by transformed w. The quotient magnitude is truncated toward zero and always clamped into the signed 32-bit range.
- R5: With `sat_en` high, a product, sum or viewport result beyond the 32-bit range becomes 0x7FFFFFFF or 0x80000000.
- R6: With `sat_en` low, such a result keeps only its low 32 bits.
- R7: When transformed w is zero, `div_zero` is set with `done`. Each of x, y and z then becomes 0x7FFFFFFF if its numerator is non-negative and 0x80000000 if it is negative. `div_zero` holds until the next result.
- R8: `ras_x` = (ndc_x + 1.0)·`scr_w`/2 and `ras_y` = (1.0 − ndc_y)·`scr_h`/2, with row 0 at the top. The final halving is an arithmetic shift right by one, and the screen sizes are unsigned whole pixels.
- R9: `done` is high for exactly one cycle per run. `ras_x`, `ras_y`, `ndc_z` and `div_zero` change only in that cycle.
- R10: `start` is ignored while `busy` is high. Load writes are also ignored while `busy` is high.
- R11: Synchronous reset clears `busy`, `done`, `div_zero` and all result outputs.
- R12: Load address `ld_addr` 0 to 15 writes M[addr/4][addr%4] (row-major). Addresses 16, 17, 18 and 19 write vertex x, y, z and w. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe |
| ld_addr | input | 5 | Load address (matrix 0-15, vertex 16-19) |
| ld_data | input | 32 | Q16.16 word to load |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| scr_w | input | 16 | Screen width in pixels |
| scr_h | input | 16 | Screen height in pixels |
| start | input | 1 | Begin a transform |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ras_x | output | 32 | Raster x, Q16.16 |
| ras_y | output | 32 | Raster y, Q16.16 |
| ndc_z | output | 32 | Normalized depth, Q16.16 |
| div_zero | output | 1 | Transformed w was zero |

## Verification
An identity matrix with w of one passes coordinates straight to the viewport, which isolates the viewport mapping and the y inversion. A sparse projection-like matrix with off-diagonal terms and a w other than one separates a post-multiply from a pre-multiply, and it exercises the divider's truncation. A huge diagonal coefficient is run twice, once clamped and once wrapped, to tell the two overflow modes apart. A zero w and a one-LSB negative product cover the divide-by-zero path and the floor rounding. A second `start` during a run, and a load during a run, must leave both the timing and the result untouched.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
    localparam int QW     = 32;
    localparam int FRAC   = 16;
    localparam int NDIM   = 4;
    localparam int NMAT   = NDIM * NDIM;
    localparam int QBITS  = QW + FRAC;
    localparam int ADDR_W = 5;

    typedef logic signed [QW-1:0] q_t;

    localparam q_t Q_MAX = 32'sh7FFFFFFF;
    localparam q_t Q_MIN = 32'sh80000000;
    localparam q_t Q_ONE = 32'sh00010000;

    localparam logic signed [63:0] W_MAX = 64'sh000000007FFFFFFF;
    localparam logic signed [63:0] W_MIN = -64'sh0000000080000000;

    typedef enum logic [2:0] {S_IDLE, S_MAC, S_DIVL, S_DIVW, S_VIEW} st_e;

    typedef struct packed {
        q_t x;
        q_t y;
        q_t z;
    } trio_t;

    function automatic q_t q_fit(input logic signed [63:0] v, input logic sat);
        if (sat && v > W_MAX) return Q_MAX;
        if (sat && v < W_MIN) return Q_MIN;
        return v[QW-1:0];
    endfunction

    function automatic q_t q_mul(input q_t a, input q_t b, input logic sat);
        logic signed [63:0] ae, be, p;
        ae = 64'(a);
        be = 64'(b);
        p  = ae * be;
        return q_fit(p >>> FRAC, sat);
    endfunction

    function automatic q_t q_add(input q_t a, input q_t b, input logic sat);
        logic signed [63:0] ae, be;
        ae = 64'(a);
        be = 64'(b);
        return q_fit(ae + be, sat);
    endfunction

    function automatic q_t q_sub(input q_t a, input q_t b, input logic sat);
        logic signed [63:0] ae, be;
        ae = 64'(a);
        be = 64'(b);
        return q_fit(ae - be, sat);
    endfunction

    function automatic logic [QW-1:0] q_mag(input q_t a);
        return a[QW-1] ? (~a + 1'b1) : a;
    endfunction

    function automatic q_t q_signed_mag(input logic [QBITS-1:0] mag, input logic neg);
        logic signed [63:0] m;
        m = $signed({{(64-QBITS){1'b0}}, mag});
        if (neg) return (m > -W_MIN) ? Q_MIN : q_fit(-m, 1'b0);
        return (m > W_MAX) ? Q_MAX : q_fit(m, 1'b0);
    endfunction
endpackage

// File: rtl/vtx_mac.sv
module vtx_mac
    import vtx_pkg::*;
(
    input  q_t   acc,
    input  q_t   coef,
    input  q_t   comp,
    input  logic sat,
    output q_t   sum
);
    q_t prod;
    always_comb begin
        prod = q_mul(coef, comp, sat);
        sum  = q_add(acc, prod, sat);
    end
endmodule

// File: rtl/vtx_div.sv
module vtx_div #(
    parameter int DW = 32,
    parameter int NB = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NB-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [NB-1:0] quot,
    output logic          ready
);
    localparam int CW = $clog2(NB + 1);

    logic [DW-1:0] rem;
    logic [NB-1:0] dq;
    logic [CW-1:0] cnt;
    logic [DW:0]   shifted, diff;

    always_comb begin
        shifted = {rem, dq[NB-1]};
        diff    = shifted - {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            dq  <= '0;
            cnt <= '0;
        end else if (start) begin
            rem <= '0;
            dq  <= dividend;
            cnt <= CW'(NB);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (shifted >= {1'b0, divisor}) begin
                rem <= diff[DW-1:0];
                dq  <= {dq[NB-2:0], 1'b1};
            end else begin
                rem <= shifted[DW-1:0];
                dq  <= {dq[NB-2:0], 1'b0};
            end
        end
    end

    assign quot  = dq;
    assign ready = (cnt == '0);
endmodule

// File: rtl/vtx_view.sv
module vtx_view
    import vtx_pkg::*;
(
    input  q_t          nx,
    input  q_t          ny,
    input  logic [15:0] sw,
    input  logic [15:0] sh,
    input  logic        sat,
    output q_t          rx,
    output q_t          ry
);
    q_t tx, ty;
    logic signed [63:0] px, py, we, he;
    always_comb begin
        tx = q_add(nx, Q_ONE, sat);
        ty = q_sub(Q_ONE, ny, sat);
        we = $signed({48'b0, sw});
        he = $signed({48'b0, sh});
        px = 64'(tx) * we;
        py = 64'(ty) * he;
        rx = q_fit(px >>> 1, sat);
        ry = q_fit(py >>> 1, sat);
    end
endmodule

// File: rtl/vtx_xform_unit.sv
module vtx_xform_unit
    import vtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [QW-1:0]     ld_data,
    input  logic              sat_en,
    input  logic [15:0]       scr_w,
    input  logic [15:0]       scr_h,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [QW-1:0]     ras_x,
    output logic [QW-1:0]     ras_y,
    output logic [QW-1:0]     ndc_z,
    output logic              div_zero
);
    localparam int SW = $clog2(NMAT);
    localparam int CB = $clog2(NDIM);

    st_e           state;
    q_t            mat [NMAT];
    q_t            vec [NDIM];
    q_t            tv  [NDIM];
    q_t            acc, mac_sum;
    logic [SW-1:0] step;
    logic [CB-1:0] row, col;
    trio_t         ndc;
    q_t            rx, ry;
    logic [2:0]    dv_rdy;
    logic [QBITS-1:0] dv_q [3];
    logic          w_zero;

    assign row    = step[SW-1:CB];
    assign col    = step[CB-1:0];
    assign busy   = (state != S_IDLE);
    assign w_zero = (tv[3] == '0);

    vtx_mac u_mac (
        .acc (acc),
        .coef(mat[step]),
        .comp(vec[col]),
        .sat (sat_en),
        .sum (mac_sum)
    );

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_div
            q_t num_c;
            assign num_c = tv[gi];
            vtx_div #(.DW(QW), .NB(QBITS)) u_div (
                .clk     (clk),
                .rst     (rst),
                .start   (state == S_DIVL),
                .dividend({q_mag(num_c), {FRAC{1'b0}}}),
                .divisor (q_mag(tv[3])),
                .quot    (dv_q[gi]),
                .ready   (dv_rdy[gi])
            );
        end
    endgenerate

    function automatic q_t finish_q(input q_t num, input logic [QBITS-1:0] mag);
        if (w_zero) return num[QW-1] ? Q_MIN : Q_MAX;
        return q_signed_mag(mag, num[QW-1] ^ tv[3][QW-1]);
    endfunction

    always_comb begin
        ndc.x = finish_q(tv[0], dv_q[0]);
        ndc.y = finish_q(tv[1], dv_q[1]);
        ndc.z = finish_q(tv[2], dv_q[2]);
    end

    vtx_view u_view (
        .nx (ndc.x),
        .ny (ndc.y),
        .sw (scr_w),
        .sh (scr_h),
        .sat(sat_en),
        .rx (rx),
        .ry (ry)
    );

    always_ff @(posedge clk) begin
        if (ld_en && !busy) begin
            if (ld_addr < ADDR_W'(NMAT))
                mat[ld_addr[SW-1:0]] <= ld_data;
            else if (ld_addr < ADDR_W'(NMAT + NDIM))
                vec[ld_addr[CB-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            step     <= '0;
            acc      <= '0;
            done     <= 1'b0;
            div_zero <= 1'b0;
            ras_x    <= '0;
            ras_y    <= '0;
            ndc_z    <= '0;
            for (int i = 0; i < NDIM; i++) tv[i] <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    state <= S_MAC;
                    step  <= '0;
                    acc   <= '0;
                end
                S_MAC: begin
                    step <= step + 1'b1;
                    if (col == CB'(NDIM - 1)) begin
                        tv[row] <= mac_sum;
                        acc     <= '0;
                        if (row == CB'(NDIM - 1)) state <= S_DIVL;
                    end else begin
                        acc <= mac_sum;
                    end
                end
                S_DIVL: state <= S_DIVW;
                S_DIVW: if (&dv_rdy) state <= S_VIEW;
                S_VIEW: begin
                    ras_x    <= rx;
                    ras_y    <= ry;
                    ndc_z    <= ndc.z;
                    div_zero <= w_zero;
                    done     <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vtx_xform_unit_chk.sv
module vtx_xform_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] ras_x,
    input logic [31:0] ras_y,
    input logic [31:0] ndc_z,
    input logic        div_zero
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done)); // R10

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy && !done && !div_zero && ras_x == 32'd0)); // R11

    AST_DIV0_FULLSCALE: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (ndc_z == 32'h7FFFFFFF || ndc_z == 32'h80000000)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(ras_x) && $stable(ras_y) && $stable(ndc_z))); // R9
endmodule

bind vtx_xform_unit vtx_xform_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .ras_x   (ras_x),
    .ras_y   (ras_y),
    .ndc_z   (ndc_z),
    .div_zero(div_zero)
);

// File: tb/vtx_xform_unit_tb.sv
module vtx_xform_unit_tb;
    localparam int LAT = 16 + 48 + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        sat_en = 1'b0;
    logic [15:0] scr_w = 16'd640;
    logic [15:0] scr_h = 16'd480;
    logic        start = 1'b0;
    logic        busy, done, div_zero;
    logic [31:0] ras_x, ras_y, ndc_z;

    always #4 clk = ~clk;

    vtx_xform_unit u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .sat_en(sat_en), .scr_w(scr_w), .scr_h(scr_h), .start(start),
        .busy(busy), .done(done), .ras_x(ras_x), .ras_y(ras_y), .ndc_z(ndc_z),
        .div_zero(div_zero)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    longint mm [16];
    longint mv [4];
    int     m_cnt = 0;
    bit     m_busy = 0, m_done = 0, m_dz = 0, p_dz = 0;
    longint m_rx = 0, m_ry = 0, m_z = 0, p_rx = 0, p_ry = 0, p_z = 0;

    function automatic longint fit(longint v, bit s);
        if (s && v > 64'sh7FFFFFFF) return 64'sh7FFFFFFF;
        if (s && v < -64'sh80000000) return -64'sh80000000;
        return longint'(int'(v));
    endfunction

    function automatic longint divq(longint n, longint w, output bit dz);
        longint an, aw, mag;
        dz = (w == 0);
        if (dz) return (n < 0) ? -64'sh80000000 : 64'sh7FFFFFFF;
        an = (n < 0) ? -n : n;
        aw = (w < 0) ? -w : w;
        mag = (an <<< 16) / aw;
        if ((n < 0) != (w < 0)) return (mag > 64'sh80000000) ? -64'sh80000000 : -mag;
        return (mag > 64'sh7FFFFFFF) ? 64'sh7FFFFFFF : mag;
    endfunction

    task automatic model_run();
        longint t [4];
        longint nx, ny, acc;
        bit dz;
        for (int i = 0; i < 4; i++) begin
            acc = 0;
            for (int j = 0; j < 4; j++)
                acc = fit(acc + fit((mm[i*4+j] * mv[j]) >>> 16, sat_en), sat_en);
            t[i] = acc;
        end
        nx  = divq(t[0], t[3], dz);
        ny  = divq(t[1], t[3], dz);
        p_z = divq(t[2], t[3], dz);
        p_dz = dz;
        p_rx = fit((fit(nx + 65536, sat_en) * longint'(scr_w)) >>> 1, sat_en);
        p_ry = fit((fit(65536 - ny, sat_en) * longint'(scr_h)) >>> 1, sat_en);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_rx = 0; m_ry = 0; m_z = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == LAT) begin
                    m_busy = 0; m_done = 1;
                    m_rx = p_rx; m_ry = p_ry; m_z = p_z; m_dz = p_dz;
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0;
                model_run();
            end
            if (ld_en && !m_busy && ld_addr < 20) begin
                if (ld_addr < 16) mm[ld_addr] = longint'($signed(ld_data));
                else mv[ld_addr-16] = longint'($signed(ld_data));
            end
        end
    end

    // per-cycle comparison away from the active edge
    int cyc = 0;
    bit wd_hit = 0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R3 done", done, m_done);
            chk("R3 busy", busy, m_busy);
            chk("R8 ras_x", longint'($signed(ras_x)), m_rx);
            chk("R8 ras_y", longint'($signed(ras_y)), m_ry);
            chk("R4 ndc_z", longint'($signed(ndc_z)), m_z);
            chk("R7 div_zero", div_zero, m_dz);
        end
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic ld(input int a, input longint d);
        @(negedge clk);
        ld_en = 1; ld_addr = 5'(a); ld_data = 32'(d);
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic ld_mat(input longint m [16]);
        for (int i = 0; i < 16; i++) ld(i, m[i]);
    endtask

    task automatic ld_vec(input longint x, input longint y, input longint z, input longint w);
        ld(16, x); ld(17, y); ld(18, z); ld(19, w);
    endtask

    task automatic run_wait(input bit poke);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1;                        // R10 start while busy
            ld_en = 1; ld_addr = 5'd16; ld_data = 32'h7000_0000; // R10 load while busy
            @(negedge clk);
            start = 0; ld_en = 0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    localparam longint ONE = 65536;
    longint ident [16];
    longint mtx [16];

    initial begin
        for (int i = 0; i < 16; i++) ident[i] = (i % 5 == 0) ? ONE : 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 div_zero", div_zero, 0);
        chk("R11 ras_x", ras_x, 0);
        rst = 0;

        // R2 R8 R12 identity pass-through
        ld_mat(ident);
        ld_vec(ONE/2, -ONE/4, 3*ONE/4, ONE);
        run_wait(0);
        chk("R8 identity ras_x", longint'($signed(ras_x)), 480 * ONE);
        chk("R8 identity ras_y", longint'($signed(ras_y)), 300 * ONE);

        // R2 R4 projection-like matrix, w != 1
        mtx = '{2*ONE, 0, ONE/2, 0,
                0, 3*ONE/2, 0, 0,
                0, 0, ONE, -ONE,
                0, 0, ONE, 0};
        ld_mat(mtx);
        ld_vec(ONE, -2*ONE, 3*ONE, ONE);
        run_wait(0);
        chk("R4 ndc_z", longint'($signed(ndc_z)), 43690);

        // R10 start and load during a run
        run_wait(1);
        chk("R10 ndc_z unchanged", longint'($signed(ndc_z)), 43690);

        // R7 zero w
        ld_mat(ident);
        ld_vec(-ONE, ONE/2, 0, 0);
        run_wait(0);
        chk("R7 div_zero set", div_zero, 1);
        chk("R7 ndc_z full scale", ndc_z, 32'h7FFFFFFF);

        // R5 saturating overflow
        mtx = ident; mtx[0] = 300 * ONE;
        ld_mat(mtx);
        ld_vec(300 * ONE, 0, ONE/2, ONE);
        sat_en = 1;
        run_wait(0);
        chk("R5 div_zero cleared", div_zero, 0);
        chk("R5 clamped ras_x", longint'($signed(ras_x)), 64'sh7FFFFFFF);
        // R6 wrapping overflow
        sat_en = 0;
        run_wait(0);
        chk("R6 ndc_z", longint'($signed(ndc_z)), ONE/2);

        // R1 floor rounding of a tiny negative product
        mtx = ident; mtx[10] = ONE/2;
        ld_mat(mtx);
        ld_vec(0, 0, -1, ONE);
        run_wait(0);
        chk("R1 floor ndc_z", longint'($signed(ndc_z)), -1);

        // R8 other screen size, negative x
        scr_w = 16'd1920; scr_h = 16'd1080;
        ld_mat(ident);
        ld_vec(-ONE/2, ONE, 0, 2*ONE);
        run_wait(0);
        chk("R8 ras_x 1920", longint'($signed(ras_x)), 720 * ONE);
        chk("R8 ras_y 1080", longint'($signed(ras_y)), 270 * ONE);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule